// File: doc/BRIEF.md
# Relocatable Peripheral Chip-Select Decoder

This block sits on a 16-bit I/O bus in front of a combined peripheral controller. Every read or write strobe has its address compared against four function windows: a disk channel with a command block and a separate control address, a floppy controller, a parallel port and a serial port. For the winning function it raises one bit of a one-hot select vector and presents the register offset inside that function's window. The peripherals behind the selects are not part of the block.

Where the parallel and serial ports sit, and which functions answer at all, comes from a bank of sixteen 8-bit configuration registers. Software reaches the bank through an index/data port pair. That pair is hidden behind a five-write unlock handshake, and one step of the handshake moves the pair to a new base address. Reprogrammable bases are configuration bytes shifted left by two bit positions.

Top module: `pio_sel_top`

## Requirements
- R1: After reset the configuration bytes at indices 0..15 are 0E,00,08,00,FE,BE,9E,00,EC,B0,00,00,00,00,00,00 and the index/data pair sits at 0x390/0x391. So the parallel port answers at 0x278..0x27B and the serial port at 0x3F8..0x3FF, while the disk channel and the floppy controller are disabled.
- R2: When enabled, the disk channel's command select (sel bit 0) covers 0x1F0..0x1F7 with offset = addr[2:0]. Its control select (sel bit 1) covers only 0x3F6, with offset 6.
- R3: When enabled, the floppy select (sel bit 2) covers 0x3F0..0x3F7 with offset = addr[2:0], except 0x3F0, 0x3F1 and 0x3F6, which never raise it.
- R4: The parallel select (sel bit 3) covers a 4-byte window with offset = {0, addr[1:0]}. The serial select (sel bit 4) covers an 8-byte window with offset = addr[2:0].
- R5: Byte 0 bit 3 enables the parallel port and bit 2 the serial port. Byte 12 bit 7 enables the disk channel and bit 5 the floppy controller. A disabled function never raises its select.
- R6: The serial base is (byte 4 AND 0xFE) << 2. The parallel base is byte 6 << 2. A new value takes effect on the cycle after the write.
- R7: The unlock handshake takes five consecutive writes: 0x55 to 0x2FA, 0xAA to 0x3FA, 0x36 to 0x3FA, any byte B to 0x3FA, then ~B to 0x2FA. Any other write before the fifth step returns it to the start. While it is locked, writes to the index/data pair change nothing.
- R8: The fourth write stores B in byte 15 and moves the index/data pair to B << 2 and (B << 2) + 1. The old pair address then has no effect.
- R9: While unlocked, a write to the index port loads the index (data bits 3:0). A write to the data port stores the data in the indexed byte. A data write while the index is 15 stores nothing and locks the bank again.
- R10: Selects are combinational from the address and a read or write strobe, none without a strobe, and at most one at a time. On overlap the priority is disk command, disk control, floppy, parallel, then serial. With no select the offset is 0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration state |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| sel | output | 5 | One-hot function select (bit order in R2 to R4) |
| reg_off | output | 3 | Register offset within the selected window |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data and a 16-entry bank. With these, byte-shifted bases can land anywhere in the lower 1 KiB, so random relocations of the parallel and serial ports and of the configuration pair create overlaps with the fixed disk and floppy windows and with each other. That exercises the priority order and the floppy holes alongside the unlock handshake, including its failure paths.

// File: rtl/pio_sel_pkg.sv
package pio_sel_pkg;

   // select vector bit positions
   localparam int SEL_IDE_CMD = 0;
   localparam int SEL_IDE_CTL = 1;
   localparam int SEL_FLOPPY  = 2;
   localparam int SEL_PAR     = 3;
   localparam int SEL_SER     = 4;
   localparam int NUM_SEL     = 5;

   // address windows compared in parallel
   localparam int WIN_IDE     = 0;
   localparam int WIN_FLOPPY  = 1;
   localparam int WIN_PAR     = 2;
   localparam int WIN_SER     = 3;
   localparam int NUM_WIN     = 4;

   // configuration byte indices and enable bit positions
   localparam int IX_ENA_LO   = 0;
   localparam int IX_SER_BASE = 4;
   localparam int IX_PAR_BASE = 6;
   localparam int IX_ENA_HI   = 12;
   localparam int BIT_PAR_EN  = 3;
   localparam int BIT_SER_EN  = 2;
   localparam int BIT_IDE_EN  = 7;
   localparam int BIT_FDC_EN  = 5;

   typedef enum logic [2:0] {
      UL_IDLE,
      UL_KEY1,
      UL_KEY2,
      UL_MOVE,
      UL_CONFIRM,
      UL_OPEN
   } unlock_st_t;

   function automatic int win_span_log2(input int w);
      return (w == WIN_PAR) ? 2 : 3;
   endfunction

   function automatic logic [7:0] cfg_reset_val(input int i);
      case (i)
         0:       return 8'h0E;
         2:       return 8'h08;
         4:       return 8'hFE;
         5:       return 8'hBE;
         6:       return 8'h9E;
         8:       return 8'hEC;
         9:       return 8'hB0;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/pio_sel_window.sv
module pio_sel_window #(
   parameter int ADDR_W    = 16,
   parameter int SPAN_LOG2 = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   output logic              hit
);

   generate
      if (SPAN_LOG2 < 1 || SPAN_LOG2 >= ADDR_W) begin : g_bad_span
         $error("pio_sel_window: SPAN_LOG2 out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] diff;

   always_comb begin
      diff = (addr ^ base) >> SPAN_LOG2;
      hit  = en && (diff == '0);
   end

endmodule

// File: rtl/pio_sel_unlock.sv
module pio_sel_unlock
   import pio_sel_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h02FA,
   parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h03FA,
   parameter logic [DATA_W-1:0] KEY_0      = 8'h55,
   parameter logic [DATA_W-1:0] KEY_1      = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_2      = 8'h36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              relock,
   output logic              unlocked,
   output logic              move_we
);

   unlock_st_t        st_q, st_d;
   logic [DATA_W-1:0] moved_q;
   logic              hit_a, hit_b;

   always_comb begin
      hit_a   = (addr == KEY_ADDR_A);
      hit_b   = (addr == KEY_ADDR_B);
      move_we = wr_en && (st_q == UL_MOVE) && hit_b;
      st_d    = st_q;
      if (st_q == UL_OPEN) begin
         if (relock) st_d = UL_IDLE;
      end else if (wr_en) begin
         st_d = UL_IDLE;
         case (st_q)
            UL_IDLE:    if (hit_a && wdata == KEY_0)    st_d = UL_KEY1;
            UL_KEY1:    if (hit_b && wdata == KEY_1)    st_d = UL_KEY2;
            UL_KEY2:    if (hit_b && wdata == KEY_2)    st_d = UL_MOVE;
            UL_MOVE:    if (hit_b)                      st_d = UL_CONFIRM;
            UL_CONFIRM: if (hit_a && wdata == ~moved_q) st_d = UL_OPEN;
            default:                                    st_d = UL_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= UL_IDLE;
         moved_q <= '0;
      end else begin
         st_q <= st_d;
         if (move_we) moved_q <= wdata;
      end
   end

   assign unlocked = (st_q == UL_OPEN);

endmodule

// File: rtl/pio_sel_cfgbank.sv
module pio_sel_cfgbank
   import pio_sel_pkg::*;
#(
   parameter int                ADDR_W       = 16,
   parameter int                DATA_W       = 8,
   parameter int                NUM_REGS     = 16,
   parameter logic [ADDR_W-1:0] CFG_BASE_RST = 16'h0390
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [DATA_W-1:0]                  wdata,
   input  logic                               unlocked,
   input  logic                               move_we,
   output logic [NUM_REGS-1:0][DATA_W-1:0]    regs,
   output logic [ADDR_W-1:0]                  cfg_base,
   output logic                               relock
);

   localparam int IDX_W = $clog2(NUM_REGS);
   localparam int LAST  = NUM_REGS - 1;
   localparam int PAD_W = ADDR_W - DATA_W - 2;

   generate
      if ((1 << IDX_W) != NUM_REGS || IDX_W > DATA_W) begin : g_bad_regs
         $error("pio_sel_cfgbank: NUM_REGS must be a power of two indexable by one data byte");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic             idx_we, dat_we;

   always_comb begin
      idx_we = wr_en && unlocked && (addr == cfg_base);
      dat_we = wr_en && unlocked && (addr == cfg_base + ADDR_W'(1));
      relock = dat_we && (idx_q == IDX_W'(LAST));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_base <= CFG_BASE_RST;
         idx_q    <= '0;
      end else begin
         if (move_we) cfg_base <= {{PAD_W{1'b0}}, wdata, 2'b00};
         if (idx_we)  idx_q    <= wdata[IDX_W-1:0];
      end
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == LAST) begin : g_move
         // the top byte records the pair relocation and is not data-writable
         always_ff @(posedge clk) begin
            if (!rst_n)       regs[g] <= DATA_W'(cfg_reset_val(g));
            else if (move_we) regs[g] <= wdata;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)                                 regs[g] <= DATA_W'(cfg_reset_val(g));
            else if (dat_we && idx_q == IDX_W'(g))      regs[g] <= wdata;
         end
      end
   end

endmodule

// File: rtl/pio_sel_top.sv
module pio_sel_top
   import pio_sel_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                DATA_W        = 8,
   parameter int                NUM_REGS      = 16,
   parameter int                OFF_W         = 3,
   parameter logic [ADDR_W-1:0] IDE_CMD_BASE  = 16'h01F0,
   parameter logic [ADDR_W-1:0] IDE_CTL_ADDR  = 16'h03F6,
   parameter logic [ADDR_W-1:0] FLOPPY_BASE   = 16'h03F0,
   parameter logic [ADDR_W-1:0] FLOPPY_HOLE_A = 16'h03F0,
   parameter logic [ADDR_W-1:0] FLOPPY_HOLE_B = 16'h03F1,
   parameter logic [ADDR_W-1:0] CFG_BASE_RST  = 16'h0390
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_rd,
   input  logic               bus_wr,
   output logic [NUM_SEL-1:0] sel,
   output logic [OFF_W-1:0]   reg_off
);

   localparam int PAD_W    = ADDR_W - DATA_W - 2;
   localparam int PAR_SPAN = win_span_log2(WIN_PAR);

   generate
      if (DATA_W != 8)                begin : g_bad_data  $error("pio_sel_top: DATA_W must be 8"); end
      if (PAD_W < 0)                  begin : g_bad_addr  $error("pio_sel_top: ADDR_W too small"); end
      if (NUM_REGS <= IX_ENA_HI)      begin : g_bad_regs  $error("pio_sel_top: bank too small"); end
      if (OFF_W != win_span_log2(WIN_SER)) begin : g_bad_off $error("pio_sel_top: OFF_W must match widest window"); end
   endgenerate

   logic [NUM_REGS-1:0][DATA_W-1:0] cfg_regs;
   logic [ADDR_W-1:0]               cfg_base;
   logic                            unlocked, move_we, relock;

   pio_sel_unlock #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .relock   (relock),
      .unlocked (unlocked),
      .move_we  (move_we)
   );

   pio_sel_cfgbank #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .NUM_REGS     (NUM_REGS),
      .CFG_BASE_RST (CFG_BASE_RST)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .unlocked (unlocked),
      .move_we  (move_we),
      .regs     (cfg_regs),
      .cfg_base (cfg_base),
      .relock   (relock)
   );

   logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
   logic [NUM_WIN-1:0]             win_en;
   logic [NUM_WIN-1:0]             win_hit;

   always_comb begin
      win_base[WIN_IDE]    = IDE_CMD_BASE;
      win_base[WIN_FLOPPY] = FLOPPY_BASE;
      win_base[WIN_PAR]    = {{PAD_W{1'b0}}, cfg_regs[IX_PAR_BASE], 2'b00};
      win_base[WIN_SER]    = {{PAD_W{1'b0}}, cfg_regs[IX_SER_BASE] & ~DATA_W'(1), 2'b00};
      win_en[WIN_IDE]      = cfg_regs[IX_ENA_HI][BIT_IDE_EN];
      win_en[WIN_FLOPPY]   = cfg_regs[IX_ENA_HI][BIT_FDC_EN];
      win_en[WIN_PAR]      = cfg_regs[IX_ENA_LO][BIT_PAR_EN];
      win_en[WIN_SER]      = cfg_regs[IX_ENA_LO][BIT_SER_EN];
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      pio_sel_window #(
         .ADDR_W    (ADDR_W),
         .SPAN_LOG2 (win_span_log2(w))
      ) u_win (
         .base (win_base[w]),
         .addr (bus_addr),
         .en   (win_en[w]),
         .hit  (win_hit[w])
      );
   end

   logic strobe, ide_ctl_hit, floppy_hole;

   always_comb begin
      strobe      = bus_rd || bus_wr;
      ide_ctl_hit = win_en[WIN_IDE] && (bus_addr == IDE_CTL_ADDR);
      floppy_hole = (bus_addr == FLOPPY_HOLE_A) || (bus_addr == FLOPPY_HOLE_B) ||
                    (bus_addr == IDE_CTL_ADDR);
      sel         = '0;
      reg_off     = '0;
      if (strobe) begin
         if (win_hit[WIN_IDE]) begin
            sel[SEL_IDE_CMD] = 1'b1;
            reg_off          = bus_addr[OFF_W-1:0];
         end else if (ide_ctl_hit) begin
            sel[SEL_IDE_CTL] = 1'b1;
            reg_off          = bus_addr[OFF_W-1:0];
         end else if (win_hit[WIN_FLOPPY] && !floppy_hole) begin
            sel[SEL_FLOPPY]  = 1'b1;
            reg_off          = bus_addr[OFF_W-1:0];
         end else if (win_hit[WIN_PAR]) begin
            sel[SEL_PAR]     = 1'b1;
            reg_off          = bus_addr[OFF_W-1:0] & OFF_W'((1 << PAR_SPAN) - 1);
         end else if (win_hit[WIN_SER]) begin
            sel[SEL_SER]     = 1'b1;
            reg_off          = bus_addr[OFF_W-1:0];
         end
      end
   end

endmodule

// File: rtl/pio_sel_checker.sv
module pio_sel_checker
   import pio_sel_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                DATA_W        = 8,
   parameter int                NUM_REGS      = 16,
   parameter int                OFF_W         = 3,
   parameter logic [ADDR_W-1:0] IDE_CTL_ADDR  = 16'h03F6,
   parameter logic [ADDR_W-1:0] FLOPPY_HOLE_A = 16'h03F0,
   parameter logic [ADDR_W-1:0] FLOPPY_HOLE_B = 16'h03F1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic                            bus_rd,
   input logic                            bus_wr,
   input logic [NUM_SEL-1:0]              sel,
   input logic [OFF_W-1:0]                reg_off,
   input logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input logic [ADDR_W-1:0]               cfg_base,
   input logic                            unlocked
);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R10

   AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |-> (sel == '0)); // R10

   AST_IDE_CTL_SPOT: assert property (@(posedge clk) disable iff (!rst_n)
      sel[SEL_IDE_CTL] |-> (bus_addr == IDE_CTL_ADDR && reg_off == OFF_W'(6))); // R2

   AST_FLOPPY_HOLES: assert property (@(posedge clk) disable iff (!rst_n)
      sel[SEL_FLOPPY] |-> (bus_addr != FLOPPY_HOLE_A && bus_addr != FLOPPY_HOLE_B &&
                           bus_addr != IDE_CTL_ADDR)); // R3

   AST_PAR_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sel[SEL_PAR] |-> (reg_off[OFF_W-1] == 1'b0)); // R4

   AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(cfg_base)); // R8

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(regs)); // R9

   AST_OPEN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(bus_wr)); // R7

endmodule

bind pio_sel_top pio_sel_checker #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .NUM_REGS      (NUM_REGS),
   .OFF_W         (OFF_W),
   .IDE_CTL_ADDR  (IDE_CTL_ADDR),
   .FLOPPY_HOLE_A (FLOPPY_HOLE_A),
   .FLOPPY_HOLE_B (FLOPPY_HOLE_B)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .sel      (sel),
   .reg_off  (reg_off),
   .regs     (cfg_regs),
   .cfg_base (cfg_base),
   .unlocked (unlocked)
);

// File: tb/pio_sel_top_bench.sv
module pio_sel_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  sel;
   logic [2:0]  reg_off;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // bench-side model of the configuration state
   logic [7:0]  m_reg [16];
   logic [15:0] m_pair;
   bit          m_open;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_sel_top u_pio_sel_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .sel       (sel),
      .reg_off   (reg_off)
   );

   function automatic logic [15:0] par_base();
      return {6'd0, m_reg[6], 2'b00};
   endfunction

   function automatic logic [15:0] ser_base();
      return {6'd0, m_reg[4] & 8'hFE, 2'b00};
   endfunction

   function automatic void expect_of(input logic [15:0] a, output logic [4:0] s, output logic [2:0] o);
      bit ide_on, fdc_on, par_on, ser_on;
      ide_on = m_reg[12][7];
      fdc_on = m_reg[12][5];
      par_on = m_reg[0][3];
      ser_on = m_reg[0][2];
      s = 5'b0;
      o = 3'd0;
      if (ide_on && a >= 16'h01F0 && a <= 16'h01F7) begin
         s = 5'b00001; o = a[2:0];
      end else if (ide_on && a == 16'h03F6) begin
         s = 5'b00010; o = 3'd6;
      end else if (fdc_on && a >= 16'h03F2 && a <= 16'h03F7 && a != 16'h03F6) begin
         s = 5'b00100; o = a[2:0];
      end else if (par_on && a >= par_base() && a < par_base() + 16'd4) begin
         s = 5'b01000; o = {1'b0, a[1:0]};
      end else if (ser_on && a >= ser_base() && a < ser_base() + 16'd8) begin
         s = 5'b10000; o = a[2:0];
      end
   endfunction

   task automatic check(input string req, input logic [15:0] a, input logic [4:0] es, input logic [2:0] eo);
      n_chk++;
      if (sel !== es || reg_off !== eo) begin
         n_fail++;
         $display("FAIL %s addr=%h actual sel=%b off=%0d expected sel=%b off=%0d",
                  req, a, sel, reg_off, es, eo);
      end
   endtask

   task automatic probe(input string req, input logic [15:0] a);
      logic [4:0] es;
      logic [2:0] eo;
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      expect_of(a, es, eo);
      check(req, a, es, eo);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic unlock(input logic [7:0] b);
      bus_write(16'h02FA, 8'h55);
      bus_write(16'h03FA, 8'hAA);
      bus_write(16'h03FA, 8'h36);
      bus_write(16'h03FA, b);
      bus_write(16'h02FA, ~b);
      m_pair    = {6'd0, b, 2'b00};
      m_reg[15] = b;
      m_open    = 1'b1;
   endtask

   task automatic cfg_set(input int i, input logic [7:0] d);
      bus_write(m_pair, 8'(i));
      bus_write(m_pair + 16'd1, d);
      if (m_open) begin
         if (i == 15) m_open = 1'b0;
         else         m_reg[i] = d;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] rst_tab [16] = '{8'h0E, 8'h00, 8'h08, 8'h00, 8'hFE, 8'hBE, 8'h9E, 8'h00,
                                   8'hEC, 8'hB0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      void'($urandom(32'd7261));
      for (int i = 0; i < 16; i++) m_reg[i] = rst_tab[i];
      m_pair = 16'h0390;
      m_open = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset windows
      probe("R1", 16'h0278);
      probe("R1", 16'h027B);
      probe("R1", 16'h03FB);
      probe("R1", 16'h01F0);
      probe("R1", 16'h03F2);

      // R10: no strobe, no select
      @(negedge clk);
      bus_addr = 16'h0278;
      #1;
      check("R10", 16'h0278, 5'b0, 3'd0);

      // R7: locked writes to the pair do nothing
      bus_write(16'h0390, 8'h00);
      bus_write(16'h0391, 8'h00);
      probe("R7", 16'h0279);
      // R7: broken handshake (wrong third key) then a pair write
      bus_write(16'h02FA, 8'h55);
      bus_write(16'h03FA, 8'hAA);
      bus_write(16'h03FA, 8'h37);
      bus_write(16'h03FA, 8'h00);
      bus_write(16'h02FA, 8'hFF);
      bus_write(16'h0390, 8'h00);
      bus_write(16'h0391, 8'h00);
      probe("R7", 16'h027A);

      // R8: relocate pair to 0x280, enable disk and floppy
      unlock(8'hA0);
      cfg_set(12, 8'hA0);
      probe("R2", 16'h01F3);
      probe("R2", 16'h03F6);
      probe("R3", 16'h03F0);
      probe("R3", 16'h03F1);
      probe("R3", 16'h03F2);
      probe("R3", 16'h03F7);
      // R8: old pair address is dead
      bus_write(16'h0390, 8'h00);
      bus_write(16'h0391, 8'h00);
      probe("R8", 16'h0278);

      // R6: move serial and parallel
      cfg_set(4, 8'h5F);
      probe("R6", 16'h0178);
      probe("R6", 16'h017F);
      probe("R6", 16'h03F8);
      cfg_set(6, 8'hDE);
      probe("R6", 16'h0378);
      probe("R4", 16'h037B);
      probe("R4", 16'h037C);

      // R10: priority on overlap
      cfg_set(6, 8'h7C);
      probe("R10", 16'h01F2);
      cfg_set(4, 8'hFE);
      cfg_set(6, 8'hFE);
      probe("R10", 16'h03F9);
      probe("R10", 16'h03FD);
      cfg_set(6, 8'hFD);
      probe("R10", 16'h03F5);
      probe("R10", 16'h03F6);
      cfg_set(12, 8'h20);
      probe("R10", 16'h03F6);
      probe("R5", 16'h01F1);

      // R5: parallel disabled, serial kept
      cfg_set(6, 8'h9E);
      cfg_set(0, 8'h04);
      probe("R5", 16'h0278);
      probe("R5", 16'h03FC);

      // R9: index 15 data write locks
      cfg_set(15, 8'h00);
      cfg_set(0, 8'h0C);
      probe("R9", 16'h0279);
      probe("R9", 16'h03FE);

      // random rounds
      for (int r = 0; r < 24; r++) begin
         unlock(8'($urandom_range(8'hFF, 8'h40)));
         cfg_set(0,  8'($urandom));
         cfg_set(4,  8'($urandom));
         cfg_set(6,  8'($urandom));
         cfg_set(12, 8'($urandom));
         if (r % 2 == 0) cfg_set(15, 8'h00);
         for (int k = 0; k < 30; k++) begin
            logic [15:0] a;
            case ($urandom % 6)
               0: a = 16'h01F0 + 16'($urandom % 8);
               1: a = 16'h03F0 + 16'($urandom % 8);
               2: a = par_base() + 16'($urandom % 4);
               3: a = ser_base() + 16'($urandom % 8);
               4: a = 16'($urandom % 1024);
               default: a = 16'h03F6;
            endcase
            probe("R4", a);
         end
         if (m_open) cfg_set(15, 8'h00);
      end

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule